// File: doc/BRIEF.md
# Card power control sequencer

This block is the power-state controller of an SD/MMC host. Software writes a 2-bit mode field together with a polarity bit. From the mode the block chooses what the card pads do: float after reset, drive every line high when switched off, drive every line low during a power cycle, or hand the lines to the command and data engines once the card is powered on. It also gives the external level-shifter direction signals their polarity.

After a power-on write, the card clock starts running at once. The command and data engines stay disabled until the card clock divider has reported a fixed number of card-clock periods, 74 by default. During that hold-off, and in every state other than fully on, any start request from the engines is blocked at the block's outputs. Nothing records that a request was dropped.

Top module: `card_pwr_seq`

## Requirements
- R1: Out of reset the mode readback `pwr_mode_o` is 00, both `ck_mode_o` and `sig_mode_o` read code 00 (high-impedance), every output enable is 0 and `eng_en_o` is 0. Pad codes are: 00 high-Z, 01 drive low, 10 drive high, 11 functional.
- R2: A write of mode 00 enters the off state. Both pad codes read 10, every output enable is 1, `eng_en_o` is 0, and the readback is 00, the same value as after reset.
- R3: A write of mode 10 enters the power-cycle state. Both pad codes read 01, every output enable is 1, `eng_en_o` is 0, and the readback is 10.
- R4: A write of mode 01 leaves the state and all pad outputs unchanged.
- R5: A write of mode 11 from the reset, off or power-cycle state enters the wake-up phase. `ck_mode_o` reads 11, `sig_mode_o` reads 10, `eng_en_o` stays 0 and the readback is 11.
- R6: In the wake-up phase, `eng_en_o` rises in the cycle after the clock edge that samples the WAKE_CLKS-th `card_clk_tick_i` pulse. A tick that arrives in the same cycle as the power-on write is not counted.
- R7: A write of mode 11 during the wake-up phase or when already on neither restarts the tick count nor changes the state.
- R8: Leaving the wake-up phase with a write of 00 or 10 throws away the partial count, so the next power-on needs the full WAKE_CLKS ticks.
- R9: While `eng_en_o` is 0, `cmd_start_o` and `data_start_o` stay 0 whatever the start inputs do. While it is 1, they follow the start inputs in the same cycle.
- R10: In the on state, both pad codes read 11, `ck_oe_o` is 1, `cmd_oe_o` equals `cmd_drive_i`, and every bit of `dat_oe_o` equals `dat_drive_i`.
- R11: Every write captures `dir_pol_i`, whatever its mode field holds. `cmd_dir_o` is `cmd_oe_o` XOR polarity, and `dat_dir_o` is `dat_oe_o[0]` XOR polarity.
- R12: Asserting `rst_ni` from any state, including on, brings back the R1 outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Kernel clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pwr_wr_i | input | 1 | Write strobe for mode and polarity |
| pwr_mode_i | input | 2 | Requested mode: 00 off, 10 power cycle, 11 on, 01 reserved |
| dir_pol_i | input | 1 | Direction-signal polarity, captured on a write |
| card_clk_tick_i | input | 1 | One-cycle pulse per card-clock period from the divider |
| cmd_start_i | input | 1 | Command engine start request |
| data_start_i | input | 1 | Data engine start request |
| cmd_drive_i | input | 1 | Command engine wants to drive the command line |
| dat_drive_i | input | 1 | Data engine wants to drive the data lines |
| pwr_mode_o | output | 2 | Mode readback |
| ck_mode_o | output | 2 | Pad code for the card clock |
| sig_mode_o | output | 2 | Pad code for command and data lines |
| ck_oe_o | output | 1 | Card clock output enable |
| cmd_oe_o | output | 1 | Command line output enable |
| dat_oe_o | output | NUM_DAT | Data line output enables |
| cmd_dir_o | output | 1 | External direction for the command line |
| dat_dir_o | output | 1 | External direction for the data lines |
| eng_en_o | output | 1 | Command and data engines enabled |
| cmd_start_o | output | 1 | Gated command start |
| data_start_o | output | 1 | Gated data start |

## Verification
The bench counts the wake-up ticks one at a time, leaving uneven gaps between them. A counter that is off by one, or one that counts the tick arriving with the power-on write, lets `eng_en_o` rise one tick early or late. It also issues a second power-on partway through a wake-up, and aborts a wake-up before powering on again. A design that restarts its count or keeps a stale count would then release the engines at the wrong tick. Start requests are pulsed during the hold-off, so a gate that leaks lets them through to the engines. The bench also sweeps polarity against drive request and sends the reserved mode, which catches a swapped direction XOR or a design that treats 01 as off.

// File: rtl/card_pwr_pkg.sv
package card_pwr_pkg;
  typedef enum logic [2:0] {
    ST_RST  = 3'd0,
    ST_OFF  = 3'd1,
    ST_CYC  = 3'd2,
    ST_WAKE = 3'd3,
    ST_ON   = 3'd4
  } pwr_state_e;

  typedef enum logic [1:0] {
    PAD_HIZ  = 2'b00,
    PAD_LOW  = 2'b01,
    PAD_HIGH = 2'b10,
    PAD_FUNC = 2'b11
  } pad_mode_e;

  localparam logic [1:0] MODE_OFF = 2'b00;
  localparam logic [1:0] MODE_RSV = 2'b01;
  localparam logic [1:0] MODE_CYC = 2'b10;
  localparam logic [1:0] MODE_ON  = 2'b11;
endpackage

// File: rtl/card_pwr_wake_cnt.sv
module card_pwr_wake_cnt #(
  parameter int WAKE_CLKS = 74
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic active_i,
  input  logic tick_i,
  output logic done_o
);
  localparam int CW = (WAKE_CLKS > 1) ? $clog2(WAKE_CLKS) : 1;
  localparam logic [CW-1:0] LAST = CW'(WAKE_CLKS - 1);

  logic [CW-1:0] cnt_q;

  assign done_o = active_i & tick_i & (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (!active_i)     cnt_q <= '0;
    else if (tick_i && !done_o) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/card_pwr_fsm.sv
module card_pwr_fsm
  import card_pwr_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_i,
  input  logic [1:0] mode_i,
  input  logic       pol_i,
  input  logic       wake_done_i,
  output pwr_state_e state_o,
  output logic       pol_o,
  output logic       wake_active_o,
  output logic [1:0] mode_rd_o
);
  pwr_state_e st_q, st_d;
  logic       pol_q;

  always_comb begin
    st_d = st_q;
    if (wr_i && mode_i == MODE_OFF)       st_d = ST_OFF;
    else if (wr_i && mode_i == MODE_CYC)  st_d = ST_CYC;
    else if (wr_i && mode_i == MODE_ON &&
             st_q != ST_WAKE && st_q != ST_ON) st_d = ST_WAKE;
    else if (st_q == ST_WAKE && wake_done_i)   st_d = ST_ON;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_RST;
      pol_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (wr_i) pol_q <= pol_i;
    end
  end

  always_comb begin
    unique case (st_q)
      ST_CYC:         mode_rd_o = MODE_CYC;
      ST_WAKE, ST_ON: mode_rd_o = MODE_ON;
      default:        mode_rd_o = MODE_OFF;
    endcase
  end

  assign state_o       = st_q;
  assign pol_o         = pol_q;
  assign wake_active_o = (st_q == ST_WAKE);
endmodule

// File: rtl/card_pwr_pads.sv
module card_pwr_pads
  import card_pwr_pkg::*;
#(
  parameter int NUM_DAT = 8
) (
  input  pwr_state_e         state_i,
  input  logic               pol_i,
  input  logic               cmd_drive_i,
  input  logic               dat_drive_i,
  output logic [1:0]         ck_mode_o,
  output logic [1:0]         sig_mode_o,
  output logic               ck_oe_o,
  output logic               cmd_oe_o,
  output logic [NUM_DAT-1:0] dat_oe_o,
  output logic               cmd_dir_o,
  output logic               dat_dir_o
);
  pad_mode_e ck_m, sig_m;

  always_comb begin
    unique case (state_i)
      ST_OFF:  begin ck_m = PAD_HIGH; sig_m = PAD_HIGH; end
      ST_CYC:  begin ck_m = PAD_LOW;  sig_m = PAD_LOW;  end
      ST_WAKE: begin ck_m = PAD_FUNC; sig_m = PAD_HIGH; end
      ST_ON:   begin ck_m = PAD_FUNC; sig_m = PAD_FUNC; end
      default: begin ck_m = PAD_HIZ;  sig_m = PAD_HIZ;  end
    endcase
  end

  function automatic logic line_oe(pad_mode_e m, logic req);
    unique case (m)
      PAD_HIZ:  return 1'b0;
      PAD_FUNC: return req;
      default:  return 1'b1;
    endcase
  endfunction

  assign ck_mode_o  = ck_m;
  assign sig_mode_o = sig_m;
  assign ck_oe_o    = (ck_m != PAD_HIZ);
  assign cmd_oe_o   = line_oe(sig_m, cmd_drive_i);

  for (genvar g = 0; g < NUM_DAT; g++) begin : g_dat
    assign dat_oe_o[g] = line_oe(sig_m, dat_drive_i);
  end

  assign cmd_dir_o = cmd_oe_o ^ pol_i;
  assign dat_dir_o = dat_oe_o[0] ^ pol_i;
endmodule

// File: rtl/card_pwr_seq.sv
module card_pwr_seq
  import card_pwr_pkg::*;
#(
  parameter int NUM_DAT   = 8,
  parameter int WAKE_CLKS = 74
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               pwr_wr_i,
  input  logic [1:0]         pwr_mode_i,
  input  logic               dir_pol_i,
  input  logic               card_clk_tick_i,
  input  logic               cmd_start_i,
  input  logic               data_start_i,
  input  logic               cmd_drive_i,
  input  logic               dat_drive_i,
  output logic [1:0]         pwr_mode_o,
  output logic [1:0]         ck_mode_o,
  output logic [1:0]         sig_mode_o,
  output logic               ck_oe_o,
  output logic               cmd_oe_o,
  output logic [NUM_DAT-1:0] dat_oe_o,
  output logic               cmd_dir_o,
  output logic               dat_dir_o,
  output logic               eng_en_o,
  output logic               cmd_start_o,
  output logic               data_start_o
);
  pwr_state_e state;
  logic       pol, wake_active, wake_done;

  card_pwr_fsm u_fsm (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .wr_i          (pwr_wr_i),
    .mode_i        (pwr_mode_i),
    .pol_i         (dir_pol_i),
    .wake_done_i   (wake_done),
    .state_o       (state),
    .pol_o         (pol),
    .wake_active_o (wake_active),
    .mode_rd_o     (pwr_mode_o)
  );

  card_pwr_wake_cnt #(.WAKE_CLKS(WAKE_CLKS)) u_wake (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .active_i (wake_active),
    .tick_i   (card_clk_tick_i),
    .done_o   (wake_done)
  );

  card_pwr_pads #(.NUM_DAT(NUM_DAT)) u_pads (
    .state_i     (state),
    .pol_i       (pol),
    .cmd_drive_i (cmd_drive_i),
    .dat_drive_i (dat_drive_i),
    .ck_mode_o   (ck_mode_o),
    .sig_mode_o  (sig_mode_o),
    .ck_oe_o     (ck_oe_o),
    .cmd_oe_o    (cmd_oe_o),
    .dat_oe_o    (dat_oe_o),
    .cmd_dir_o   (cmd_dir_o),
    .dat_dir_o   (dat_dir_o)
  );

  assign eng_en_o     = (state == ST_ON);
  assign cmd_start_o  = cmd_start_i  & eng_en_o;
  assign data_start_o = data_start_i & eng_en_o;
endmodule

// File: rtl/card_pwr_seq_chk.sv
module card_pwr_seq_chk #(
  parameter int NUM_DAT   = 8,
  parameter int WAKE_CLKS = 74
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               pwr_wr_i,
  input logic [1:0]         pwr_mode_i,
  input logic               card_clk_tick_i,
  input logic [1:0]         pwr_mode_o,
  input logic [1:0]         ck_mode_o,
  input logic [1:0]         sig_mode_o,
  input logic               ck_oe_o,
  input logic [NUM_DAT-1:0] dat_oe_o,
  input logic               eng_en_o,
  input logic               cmd_start_o,
  input logic               data_start_o
);
  localparam int TW = $clog2(WAKE_CLKS + 2);
  logic [TW-1:0] tick_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 tick_cnt <= '0;
    else if (pwr_mode_o != 2'b11) tick_cnt <= '0;
    else if (card_clk_tick_i && !eng_en_o && tick_cnt <= TW'(WAKE_CLKS))
      tick_cnt <= tick_cnt + 1'b1;
  end

  AST_OFF_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwr_wr_i && pwr_mode_i == 2'b00 |=> sig_mode_o == 2'b10 && !eng_en_o); // R2
  AST_CYC_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwr_wr_i && pwr_mode_i == 2'b10 |=> ck_mode_o == 2'b01 && sig_mode_o == 2'b01 && &dat_oe_o); // R3
  AST_RSV_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwr_wr_i && pwr_mode_i == 2'b01 |=> $stable(pwr_mode_o)); // R4
  AST_WAKE_COUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(eng_en_o) |-> tick_cnt == TW'(WAKE_CLKS) && $past(card_clk_tick_i)); // R6
  AST_START_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !eng_en_o |-> !cmd_start_o && !data_start_o); // R9
  AST_ON_CLOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_en_o |-> ck_oe_o && pwr_mode_o == 2'b11); // R10
endmodule

bind card_pwr_seq card_pwr_seq_chk #(.NUM_DAT(NUM_DAT), .WAKE_CLKS(WAKE_CLKS)) u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .pwr_wr_i        (pwr_wr_i),
  .pwr_mode_i      (pwr_mode_i),
  .card_clk_tick_i (card_clk_tick_i),
  .pwr_mode_o      (pwr_mode_o),
  .ck_mode_o       (ck_mode_o),
  .sig_mode_o      (sig_mode_o),
  .ck_oe_o         (ck_oe_o),
  .dat_oe_o        (dat_oe_o),
  .eng_en_o        (eng_en_o),
  .cmd_start_o     (cmd_start_o),
  .data_start_o    (data_start_o)
);

// File: tb/card_pwr_seq_tb.sv
`timescale 1ns/1ps
module card_pwr_seq_tb_top;
  localparam int ND = 8;
  localparam int WK = 74;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr = 0, pol = 0, tick = 0, cst = 0, dst = 0, cdrv = 0, ddrv = 0;
  logic [1:0] mode = 0;
  logic [1:0] pm, ckm, sgm;
  logic ckoe, cmdoe, cdir, ddir, eng, cso, dso;
  logic [ND-1:0] doe;
  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  card_pwr_seq #(.NUM_DAT(ND), .WAKE_CLKS(WK)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .pwr_wr_i(wr), .pwr_mode_i(mode),
    .dir_pol_i(pol), .card_clk_tick_i(tick), .cmd_start_i(cst),
    .data_start_i(dst), .cmd_drive_i(cdrv), .dat_drive_i(ddrv),
    .pwr_mode_o(pm), .ck_mode_o(ckm), .sig_mode_o(sgm), .ck_oe_o(ckoe),
    .cmd_oe_o(cmdoe), .dat_oe_o(doe), .cmd_dir_o(cdir), .dat_dir_o(ddir),
    .eng_en_o(eng), .cmd_start_o(cso), .data_start_o(dso)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // packs {pm, ckm, sgm, ckoe, cmdoe, &doe, |doe, eng}
  function automatic logic [31:0] pads();
    return {20'd0, pm, ckm, sgm, ckoe, cmdoe, &doe, |doe, eng, 1'b0};
  endfunction

  function automatic logic [31:0] expv(input logic [1:0] p, input logic [1:0] c,
                                       input logic [1:0] s, input logic oe, input logic e);
    return {20'd0, p, c, s, oe, oe, oe, oe, e, 1'b0};
  endfunction

  task automatic write(input logic [1:0] m, input logic p);
    @(negedge clk); wr = 1; mode = m; pol = p;
    @(negedge clk); wr = 0;
  endtask

  task automatic ticks(input int n, input int gap);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1;
      @(negedge clk); tick = 0;
      repeat (gap) @(negedge clk);
    end
  endtask

  initial begin
    #400000;
    bad++; total++;
    $display("FAIL watchdog act=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 reset", pads(), expv(2'b00, 2'b00, 2'b00, 1'b0, 1'b0));
    check("R1 dir", {cdir, ddir}, 2'b00);
    rst_n = 1'b1;
    @(negedge clk);
    cst = 1; dst = 1; @(negedge clk);
    check("R9 gate in reset", {cso, dso}, 2'b00);
    cst = 0; dst = 0;

    // R2 off
    write(2'b00, 1'b0);
    check("R2 off", pads(), expv(2'b00, 2'b10, 2'b10, 1'b1, 1'b0));
    // R3 cycle
    write(2'b10, 1'b0);
    check("R3 cycle", pads(), expv(2'b10, 2'b01, 2'b01, 1'b1, 1'b0));
    // R4 reserved, also R11 polarity captured
    write(2'b01, 1'b1);
    check("R4 reserved", pads(), expv(2'b10, 2'b01, 2'b01, 1'b1, 1'b0));
    check("R11 pol on reserved write", {cdir, ddir}, 2'b00);
    write(2'b01, 1'b0);

    // R5 power on with a tick in the write cycle (R6: not counted)
    @(negedge clk); wr = 1; mode = 2'b11; pol = 0; tick = 1;
    @(negedge clk); wr = 0; tick = 0;
    check("R5 wake", pads() & ~32'h1f, expv(2'b11, 2'b11, 2'b10, 1'b1, 1'b0) & ~32'h1f);
    check("R5 wake sig oe", {ckoe, cmdoe, &doe, eng}, 4'b1110);
    // R6 sweep with uneven gaps
    for (int n = 1; n <= WK; n++) begin
      ticks(1, n % 3);
      check($sformatf("R6 tick %0d", n), eng, (n >= WK));
      if (n == 40) begin
        cst = 1; dst = 1; @(negedge clk);
        check("R9 gate in wake", {cso, dso}, 2'b00);
        cst = 0; dst = 0;
      end
    end
    // R9 passes when on
    cst = 1; dst = 0; @(negedge clk);
    check("R9 pass cmd", {cso, dso}, 2'b10);
    cst = 0; dst = 1; @(negedge clk);
    check("R9 pass data", {cso, dso}, 2'b01);
    dst = 0;
    // R10/R11 sweep of polarity x drive requests
    for (int p = 0; p < 2; p++) begin
      write(2'b11, p[0]);
      for (int d = 0; d < 4; d++) begin
        cdrv = d[0]; ddrv = d[1]; #1;
        check("R10 functional", {ckm, sgm, ckoe, cmdoe, doe},
              {4'b1111, 1'b1, d[0], {ND{d[1]}}});
        check("R11 dir", {cdir, ddir}, {d[0] ^ p[0], d[1] ^ p[0]});
        check("R7 on stays", {pm, eng}, 3'b111);
      end
    end
    cdrv = 0; ddrv = 0;

    // R7 re-power-on during wake does not restart
    write(2'b00, 1'b0);
    check("R2 off from on", pads(), expv(2'b00, 2'b10, 2'b10, 1'b1, 1'b0));
    write(2'b11, 1'b0);
    ticks(30, 1);
    write(2'b11, 1'b0);
    ticks(WK - 31, 0);
    check("R7 before last", eng, 1'b0);
    ticks(1, 0);
    check("R7 after last", eng, 1'b1);

    // R8 abort mid-wake, restart needs full count
    write(2'b10, 1'b0);
    write(2'b11, 1'b0);
    ticks(50, 0);
    write(2'b10, 1'b0);
    check("R8 abort cycle", pads(), expv(2'b10, 2'b01, 2'b01, 1'b1, 1'b0));
    write(2'b11, 1'b0);
    ticks(WK - 1, 0);
    check("R8 full count needed", eng, 1'b0);
    ticks(1, 2);
    check("R8 on after full", eng, 1'b1);

    // R12 reset from on
    write(2'b11, 1'b1);
    @(negedge clk); rst_n = 0; #1;
    check("R12 reset from on", pads(), expv(2'b00, 2'b00, 2'b00, 1'b0, 1'b0));
    check("R12 pol cleared", {cdir, ddir}, 2'b00);
    @(negedge clk); rst_n = 1;

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule